// File: doc/BRIEF.md
# Multichannel Peak Limiter Gain Controller

This block limits the level of a group of audio channels with two gain controllers that run independently of each other. Each channel is assigned to the first controller, to the second, or to neither. A frame strobe marks each new set of parallel samples. On that strobe, each controller finds the largest magnitude among the samples of its assigned channels. It compares that one peak with an attack level and a release level, and then moves one shared gain down or up by a programmable step. Every channel on that controller is scaled by the same gain.

A channel with no controller passes its sample through unchanged, except that it saturates at output full scale. The input samples carry headroom bits above the output width, so upstream digital gain can push a sample past full scale. Configuration is written through a small write-only register port. Each threshold comes either from a coarse 4-bit code or from a finer 7-bit extended value, and a flag bit in the extended register picks between the two.

Top module: `peak_limiter`

## Requirements
- R1: While reset is low, and on the cycle after it, both gains read 32768 (unity in Q1.15), every channel is unassigned, and out_valid and all outputs are 0.
- R2: A write to address 8+c sets the assignment of channel c from wdata[1:0]. Code 1 assigns the channel to controller 1 and code 2 assigns it to controller 2. Codes 0 and 3 leave it unassigned.
- R3: An unassigned channel outputs its input sample saturated to the range -32768..32767, whatever the gain is.
- R4: A controller's peak is the largest absolute input value among the channels assigned to it in that frame. Unassigned channels and channels on the other controller do not contribute.
- R5: The step register sits at address 4k for controller k (0 or 1). Bits 7:4 give the attack code a and bits 3:0 give the release code r. The gain steps are 2^a and 2^r LSBs of Q1.15.
- R6: The level register sits at address 4k+1. Bits 7:4 give the attack level code and bits 3:0 give the release level code. A code n means the level n*4096.
- R7: The extended attack register is at 4k+2 and the extended release register is at 4k+3. When bit 7 is 1, that level is bits 6:0 times 1024 and replaces the coarse code. When bit 7 is 0, the coarse code is used.
- R8: On a frame, if the peak is above the attack level, the gain falls by the attack step and does not go below 0. Attack takes priority over release.
- R9: On a frame without attack, if the peak is below the release level, the gain rises by the release step and does not go above 32768. Otherwise the gain is held.
- R10: The gains change only on a frame strobe. out_valid is high exactly in the cycle after a strobe.
- R11: An assigned channel outputs (x*g + 16384) >> 15, with an arithmetic shift, saturated to 16 bits. Here g is the gain held before that frame's update.
- R12: The two controllers keep separate gains and settings, and neither one affects the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| frame_valid | input | 1 | Frame strobe; samples are valid |
| in_samples | input | 72 | Four signed 18-bit samples, channel c at [18c+17:18c] |
| out_valid | output | 1 | Output samples valid |
| out_samples | output | 64 | Four signed 16-bit results, channel c at [16c+15:16c] |
| lim_gain | output | 32 | Q1.15 gain of controller k at [16k+15:16k] |

## Verification
A wrong gain state appears on lim_gain and on every assigned output in the cycle after the next frame strobe, because each frame's output uses the stored gain. An error in the peak or the level comparison therefore changes the step direction, and the error shows one frame later and keeps growing. A corrupted channel assignment shows on that channel's output in its first frame, as a pass-through value or as a value scaled by the wrong controller's gain. The reference model tracks both gains and every output each clock, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/peak_limiter_pkg.sv
// Package: shared types and constants for the peak limiter.
// Assumes exactly two gain controllers; register offsets are fixed here.
package peak_limiter_pkg;

    localparam int NUM_LIM  = 2;
    localparam int MAP_BASE = 8;

    typedef enum logic [1:0] {
        ASSIGN_NONE = 2'd0,
        ASSIGN_L1   = 2'd1,
        ASSIGN_L2   = 2'd2,
        ASSIGN_OFF  = 2'd3
    } assign_e;

    // Per-controller configuration as written through the register port
    typedef struct packed {
        logic [3:0] atk_rate;
        logic [3:0] rel_rate;
        logic [3:0] atk_code;
        logic [3:0] rel_code;
        logic       atk_ext_en;
        logic [6:0] atk_ext;
        logic       rel_ext_en;
        logic [6:0] rel_ext;
    } lim_cfg_t;

endpackage

// File: rtl/plim_regs.sv
// Register file: holds per-controller step/level settings and channel assignments.
// Assumes ADDR_W >= 4 and NUM_CH <= 8; writes take effect on the next clock.
module plim_regs
    import peak_limiter_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [7:0]                   wdata,
    output lim_cfg_t [NUM_LIM-1:0]       cfg_o,
    output logic [NUM_CH-1:0][1:0]       map_o
);

    logic                lim_hit;
    logic                map_hit;
    logic [ADDR_W-1:0]   map_idx;

    // Decode which register group the address falls in
    always_comb begin
        lim_hit = we && (addr < ADDR_W'(MAP_BASE));
        map_idx = addr - ADDR_W'(MAP_BASE);
        map_hit = we && !lim_hit && (map_idx < ADDR_W'(NUM_CH));
    end

    // Store controller settings; offset bits [1:0] pick the register, bit 2 the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (lim_hit) begin
            for (int k = 0; k < NUM_LIM; k++) begin
                if (addr[2] == 1'(k)) begin
                    case (addr[1:0])
                        2'd0: begin
                            cfg_o[k].atk_rate <= wdata[7:4];
                            cfg_o[k].rel_rate <= wdata[3:0];
                        end
                        2'd1: begin
                            cfg_o[k].atk_code <= wdata[7:4];
                            cfg_o[k].rel_code <= wdata[3:0];
                        end
                        2'd2: begin
                            cfg_o[k].atk_ext_en <= wdata[7];
                            cfg_o[k].atk_ext    <= wdata[6:0];
                        end
                        default: begin
                            cfg_o[k].rel_ext_en <= wdata[7];
                            cfg_o[k].rel_ext    <= wdata[6:0];
                        end
                    endcase
                end
            end
        end
    end

    // Store channel assignments; reset leaves every channel unassigned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_o <= '0;
        end else if (map_hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (map_idx == ADDR_W'(c)) map_o[c] <= wdata[1:0];
            end
        end
    end

endmodule

// File: rtl/plim_peak.sv
// Peak finder: largest absolute sample among channels assigned to one controller.
// Assumes two's complement samples; the most negative value maps to 2^(IN_W-1).
module plim_peak #(
    parameter int         NUM_CH  = 4,
    parameter int         IN_W    = 18,
    parameter logic [1:0] MY_CODE = 2'd1
) (
    input  logic [NUM_CH-1:0][IN_W-1:0] samples,
    input  logic [NUM_CH-1:0][1:0]      map,
    output logic [IN_W-1:0]             peak
);

    logic [NUM_CH-1:0][IN_W-1:0] mag;

    // Magnitude of each channel, zero when the channel belongs elsewhere
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (map[c] != MY_CODE)       mag[c] = '0;
            else if (samples[c][IN_W-1]) mag[c] = IN_W'(0) - samples[c];
            else                         mag[c] = samples[c];
        end
    end

    // Running maximum across channels
    always_comb begin
        peak = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (mag[c] > peak) peak = mag[c];
        end
    end

endmodule

// File: rtl/plim_gain.sv
// Gain controller: attack/release stepping of one Q1.15 gain, once per frame.
// Assumes GAIN_W >= 16 so a step of 2^15 fits; OUT_W >= 6.
module plim_gain
    import peak_limiter_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int OUT_W  = 16,
    parameter int GAIN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic [IN_W-1:0]   peak,
    input  lim_cfg_t          cfg,
    output logic [GAIN_W-1:0] gain
);

    localparam int SUM_W = GAIN_W + 1;
    localparam int THR_W = ((IN_W > OUT_W + 1) ? IN_W : OUT_W + 1) + 1;
    localparam logic [SUM_W-1:0] UNITY = SUM_W'(1) << (GAIN_W - 1);

    logic [THR_W-1:0] atk_lvl, rel_lvl, pk;
    logic [SUM_W-1:0] atk_step, rel_step, g_ext, g_up, g_next;
    logic             atk_hit, rel_hit;

    // Resolve the levels (coarse or extended) and the step sizes
    always_comb begin
        atk_lvl  = cfg.atk_ext_en ? (THR_W'(cfg.atk_ext) << (OUT_W - 6))
                                  : (THR_W'(cfg.atk_code) << (OUT_W - 4));
        rel_lvl  = cfg.rel_ext_en ? (THR_W'(cfg.rel_ext) << (OUT_W - 6))
                                  : (THR_W'(cfg.rel_code) << (OUT_W - 4));
        atk_step = SUM_W'(1) << cfg.atk_rate;
        rel_step = SUM_W'(1) << cfg.rel_rate;
        pk       = THR_W'(peak);
        atk_hit  = pk > atk_lvl;
        rel_hit  = pk < rel_lvl;
    end

    // Next gain: attack wins, then release, else hold
    always_comb begin
        g_ext = SUM_W'(gain);
        g_up  = g_ext + rel_step;
        if (atk_hit)      g_next = (g_ext > atk_step) ? g_ext - atk_step : '0;
        else if (rel_hit) g_next = (g_up >= UNITY) ? UNITY : g_up;
        else              g_next = g_ext;
    end

    // Gain register, updated only on the frame strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     gain <= GAIN_W'(UNITY);
        else if (frame) gain <= g_next[GAIN_W-1:0];
    end

endmodule

// File: rtl/plim_apply.sv
// Channel output stage: scales by the gain with rounding, or passes through, then saturates.
// Assumes gain is Q1.15-style unsigned with GAIN_W-1 fraction bits.
module plim_apply #(
    parameter int IN_W   = 18,
    parameter int OUT_W  = 16,
    parameter int GAIN_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame,
    input  logic                     bypass,
    input  logic signed [IN_W-1:0]   sample,
    input  logic [GAIN_W-1:0]        gain,
    output logic signed [OUT_W-1:0]  result
);

    localparam int FRAC   = GAIN_W - 1;
    localparam int PROD_W = IN_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC - 1);
    localparam logic signed [PROD_W-1:0] MAXV = (PROD_W'(1) << (OUT_W - 1)) - PROD_W'(1);
    localparam logic signed [PROD_W-1:0] MINV = -(PROD_W'(1) << (OUT_W - 1));

    logic signed [PROD_W-1:0] prod, rnd, val;
    logic signed [OUT_W-1:0]  sat;

    // Multiply, round half up, choose pass-through, then clamp
    always_comb begin
        prod = sample * $signed({1'b0, gain});
        rnd  = (prod + HALF) >>> FRAC;
        val  = bypass ? {{(PROD_W-IN_W){sample[IN_W-1]}}, sample} : rnd;
        if (val > MAXV)      sat = MAXV[OUT_W-1:0];
        else if (val < MINV) sat = MINV[OUT_W-1:0];
        else                 sat = val[OUT_W-1:0];
    end

    // Output register loaded on each frame
    always_ff @(posedge clk) begin
        if (!rst_n)     result <= '0;
        else if (frame) result <= sat;
    end

endmodule

// File: rtl/peak_limiter.sv
// Top: two peak-driven gain controllers shared by NUM_CH channels plus register file.
// Assumes samples arrive in parallel with a one-cycle frame strobe; output one cycle later.
module peak_limiter
    import peak_limiter_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IN_W   = 18,
    parameter int OUT_W  = 16,
    parameter int GAIN_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [7:0]                  reg_wdata,
    input  logic                        frame_valid,
    input  logic [NUM_CH*IN_W-1:0]      in_samples,
    output logic                        out_valid,
    output logic [NUM_CH*OUT_W-1:0]     out_samples,
    output logic [NUM_LIM*GAIN_W-1:0]   lim_gain
);

    lim_cfg_t [NUM_LIM-1:0]            cfg;
    logic [NUM_CH-1:0][1:0]            map;
    logic [NUM_CH-1:0][IN_W-1:0]       smp;
    logic [NUM_LIM-1:0][GAIN_W-1:0]    gains;

    assign smp      = in_samples;
    assign lim_gain = gains;

    plim_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .cfg_o(cfg), .map_o(map)
    );

    for (genvar k = 0; k < NUM_LIM; k++) begin : g_lim
        logic [IN_W-1:0] peak;

        plim_peak #(.NUM_CH(NUM_CH), .IN_W(IN_W), .MY_CODE(2'(k + 1))) peak_i (
            .samples(smp), .map(map), .peak(peak)
        );

        plim_gain #(.IN_W(IN_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)) gain_i (
            .clk(clk), .rst_n(rst_n), .frame(frame_valid),
            .peak(peak), .cfg(cfg[k]), .gain(gains[k])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              byp;
        logic [GAIN_W-1:0] gsel;

        // Route the assigned controller's gain to this channel
        always_comb begin
            case (assign_e'(map[c]))
                ASSIGN_L1: begin byp = 1'b0; gsel = gains[0]; end
                ASSIGN_L2: begin byp = 1'b0; gsel = gains[1]; end
                default:   begin byp = 1'b1; gsel = '0;       end
            endcase
        end

        plim_apply #(.IN_W(IN_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)) apply_i (
            .clk(clk), .rst_n(rst_n), .frame(frame_valid), .bypass(byp),
            .sample(smp[c]), .gain(gsel), .result(out_samples[c*OUT_W +: OUT_W])
        );
    end

    // Output valid follows the frame strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= frame_valid;
    end

endmodule

// File: rtl/peak_limiter_chk.sv
// Checker: port-level timing and range properties of the peak limiter.
// Attached to every peak_limiter instance by the bind below.
module peak_limiter_chk #(
    parameter int NUM_LIM = 2,
    parameter int GAIN_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_valid,
    input logic                      out_valid,
    input logic [NUM_LIM*GAIN_W-1:0] lim_gain
);

    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

    // R10: out_valid follows a strobe
    a_r10_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> out_valid);

    // R10: no strobe, no valid
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !out_valid);

    for (genvar k = 0; k < NUM_LIM; k++) begin : g_k
        // R10: gains move only on a strobe
        a_r10_gain_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_valid |=> $stable(lim_gain[k*GAIN_W +: GAIN_W]));

        // R9: gain never exceeds unity
        a_r9_gain_le_unity: assert property (@(posedge clk) disable iff (!rst_n)
            lim_gain[k*GAIN_W +: GAIN_W] <= UNITY);

        // R1: leaving reset the gain is unity
        a_r1_reset_unity: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) == 1'b0) |-> (lim_gain[k*GAIN_W +: GAIN_W] == UNITY));
    end

endmodule

bind peak_limiter peak_limiter_chk #(.NUM_LIM(peak_limiter_pkg::NUM_LIM), .GAIN_W(GAIN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .out_valid(out_valid), .lim_gain(lim_gain)
);

// File: tb/peak_limiter_tb.sv
module peak_limiter_tb_top;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        frame_valid = 1'b0;
    logic [NC*18-1:0] in_samples = '0;
    logic        out_valid;
    logic [NC*16-1:0] out_samples;
    logic [31:0] lim_gain;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1 reset";
    int smp [NC];

    // reference model state
    int m_gain [2];
    int m_map [NC];
    int m_rate [2], m_thr [2], m_exa [2], m_exr [2];
    int m_out [NC];
    bit m_valid;

    peak_limiter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_valid(frame_valid), .in_samples(in_samples),
        .out_valid(out_valid), .out_samples(out_samples), .lim_gain(lim_gain)
    );

    always #2ns clk = ~clk;

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // behavioural reference, evaluated at each rising edge from pre-edge inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_gain[k] = 32768; m_rate[k] = 0; m_thr[k] = 0; m_exa[k] = 0; m_exr[k] = 0;
            end
            for (int c = 0; c < NC; c++) begin m_map[c] = 0; m_out[c] = 0; end
            m_valid = 0;
        end else begin
            m_valid = frame_valid;
            if (frame_valid) begin
                int pk [2];
                pk[0] = 0; pk[1] = 0;
                for (int c = 0; c < NC; c++) begin
                    int s;
                    s = int'($signed(in_samples[c*18 +: 18]));
                    if (m_map[c] == 1 || m_map[c] == 2) begin
                        longint p;
                        int a;
                        a = (s < 0) ? -s : s;
                        if (a > pk[m_map[c]-1]) pk[m_map[c]-1] = a;
                        p = longint'(s) * m_gain[m_map[c]-1];
                        m_out[c] = sat16((p + 16384) >>> 15);
                    end else begin
                        m_out[c] = sat16(s);
                    end
                end
                for (int k = 0; k < 2; k++) begin
                    int al, rl, as, rs;
                    al = (m_exa[k] >= 128) ? (m_exa[k] % 128) * 1024 : (m_thr[k] / 16) * 4096;
                    rl = (m_exr[k] >= 128) ? (m_exr[k] % 128) * 1024 : (m_thr[k] % 16) * 4096;
                    as = 1 << (m_rate[k] / 16);
                    rs = 1 << (m_rate[k] % 16);
                    if (pk[k] > al) m_gain[k] = (m_gain[k] > as) ? m_gain[k] - as : 0;
                    else if (pk[k] < rl) m_gain[k] = (m_gain[k] + rs > 32768) ? 32768 : m_gain[k] + rs;
                end
            end
            if (reg_we) begin
                int a, d;
                a = int'(reg_addr); d = int'(reg_wdata);
                if (a < 8) begin
                    case (a % 4)
                        0: m_rate[a / 4] = d;
                        1: m_thr[a / 4] = d;
                        2: m_exa[a / 4] = d;
                        default: m_exr[a / 4] = d;
                    endcase
                end else if (a - 8 < NC) begin
                    m_map[a - 8] = d % 4;
                end
            end
        end
    end

    // compare every clock, just after the edge
    always @(posedge clk) begin
        #1ns;
        checks++;
        begin
            bit bad;
            bad = (out_valid !== m_valid);
            for (int k = 0; k < 2; k++)
                if (int'(lim_gain[k*16 +: 16]) != m_gain[k]) bad = 1;
            for (int c = 0; c < NC; c++)
                if (int'($signed(out_samples[c*16 +: 16])) != m_out[c]) bad = 1;
            if (bad) begin
                errors++;
                $display("FAIL %s cycle %0d: actual valid=%0d g=%0d/%0d o0=%0d expected valid=%0d g=%0d/%0d o0=%0d",
                    cur_req, cycles, out_valid, lim_gain[15:0], lim_gain[31:16],
                    $signed(out_samples[15:0]), m_valid, m_gain[0], m_gain[1], m_out[0]);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below 200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus, starting at a falling edge
    task automatic cyc(bit we, int a, int d, bit fr);
        reg_we = we; reg_addr = 4'(a); reg_wdata = 8'(d); frame_valid = fr;
        for (int c = 0; c < NC; c++) in_samples[c*18 +: 18] = 18'(smp[c]);
        @(negedge clk);
    endtask

    task automatic wr(int a, int d); cyc(1, a, d, 0); endtask

    task automatic frm(int s0, int s1, int s2, int s3);
        smp[0] = s0; smp[1] = s1; smp[2] = s2; smp[3] = s3;
        cyc(0, 0, 0, 1);
    endtask

    function automatic int g(int k); return int'(lim_gain[k*16 +: 16]); endfunction
    function automatic int o(int c); return int'($signed(out_samples[c*16 +: 16])); endfunction

    initial begin
        for (int c = 0; c < NC; c++) smp[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);
        chk("R1 gain1 unity", g(0), 32768);
        chk("R1 gain2 unity", g(1), 32768);
        chk("R1 valid low", int'(out_valid), 0);
        chk("R1 output zero", o(0), 0);

        cur_req = "R3 unassigned";
        frm(100000, -100000, 1234, -131072);
        chk("R3 clip high", o(0), 32767);
        chk("R3 clip low", o(1), -32768);
        chk("R3 pass", o(2), 1234);
        chk("R3 most negative", o(3), -32768);
        chk("R10 valid after frame", int'(out_valid), 1);

        cur_req = "R2/R5/R6 setup";
        wr(8, 1); wr(9, 1); wr(10, 2); wr(11, 0);
        wr(0, 8'hCA); wr(1, 8'h84);
        wr(4, 8'h00); wr(5, 8'hFF);

        cur_req = "R8 attack";
        for (int i = 0; i < 10; i++) frm(100, 60000, 1000, 50000);
        chk("R8 floor at zero", g(0), 0);
        chk("R8 output at gain zero", o(1), 0);
        chk("R12 other limiter untouched", g(1), 32768);
        chk("R3 unassigned during attack", o(3), 32767);

        cur_req = "R9 release";
        for (int i = 0; i < 40; i++) frm(1000, -1000, 0, 0);
        chk("R9 cap at unity", g(0), 32768);

        cur_req = "R9 hold";
        frm(0, 60000, 0, 0); frm(0, 60000, 0, 0);
        chk("R8 two attack steps", g(0), 24576);
        for (int i = 0; i < 3; i++) frm(0, 20000, 0, 0);
        chk("R9 hold between levels", g(0), 24576);

        cur_req = "R11 scaling";
        frm(1001, -1001, 0, 0);
        chk("R11 round positive", o(0), 751);
        chk("R11 round negative", o(1), -751);
        chk("R9 release step", g(0), 25600);
        frm(100000, 0, 0, 0);
        chk("R11 saturate", o(0), 32767);
        chk("R8 attack from peak", g(0), 21504);

        cur_req = "R7 extended";
        wr(2, 8'h94); wr(3, 8'h8A);
        frm(25000, 0, 0, 0);
        chk("R7 extended attack level", g(0), 17408);
        frm(15000, 0, 0, 0);
        chk("R7 hold between extended levels", g(0), 17408);
        frm(9000, 0, 0, 0);
        chk("R7 extended release level", g(0), 18432);

        cur_req = "R4 peak";
        frm(-30000, 5000, 90000, 120000);
        chk("R4 peak from assigned only", g(0), 14336);
        chk("R12 second limiter attack", g(1), 32767);

        cur_req = "R7 flag off";
        wr(2, 8'h14);
        frm(25000, 0, 0, 0);
        chk("R7 coarse level when flag clear", g(0), 14336);

        cur_req = "R10 idle";
        wr(0, 8'h00);
        repeat (5) cyc(0, 0, 0, 0);
        chk("R10 gain held without frame", g(0), 14336);
        chk("R10 valid low when idle", int'(out_valid), 0);

        cur_req = "R2 code three";
        wr(8, 3);
        frm(100000, 0, 0, 0);
        chk("R2 code 3 unassigned", o(0), 32767);

        cur_req = "R11 random";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 8);
            for (int c = 0; c < NC; c++) begin
                int sh;
                sh = int'($urandom % 4);
                smp[c] = (int'($urandom % 262144) - 131072) >>> (sh * 3);
            end
            if (r < 2) cyc(1, int'($urandom % 12), int'($urandom % 256), 0);
            else if (r == 2) cyc(1, int'($urandom % 12), int'($urandom % 256), 1);
            else if (r < 7) cyc(0, 0, 0, 1);
            else cyc(0, 0, 0, 0);
        end
        cyc(0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule